// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns each frame on it into a byte on a parallel output. Frames are one start bit, eight data bits sent least significant bit first, and one stop bit. Timing comes from a one-cycle clock-enable pulse, `tick_16x`, that an external programmable divider produces at sixteen times the baud rate. Every bit period is therefore sixteen ticks long.

The receiver builds its own bit-sampling strobe and drives it out on `samp_strobe`. The strobe does not have a 50% duty cycle. In each bit period it is low for six ticks and high for ten. Each bit is captured at the point where the strobe rises, which is near the middle of the bit. Between frames the strobe is parked high. A start edge that turns out to be a glitch is dropped at its mid-bit check, and the receiver goes back to waiting for a start edge.

Received bytes leave through a valid/ready stream. A byte stays presented with its flags until the consumer accepts it. The stream cannot stop the serial line, though, so back-pressure cannot stall reception. If a new byte completes while the old one is still waiting, the new byte replaces the old one and the overrun flag is raised.

Top module: `serial_rx_os16`

## Requirements
- R1: While reset is held and after it is released, `samp_strobe` is 1, `rx_valid` is 0, and `rx_frm_err` and `rx_overrun` are 0.
- R2: A frame starts only on a tick where the synchronized line is 0 and was 1 at the previous tick, and only while the receiver is idle. A line that stays low with no high-to-low transition starts nothing: no strobe activity and no byte.
- R3: After a start is detected, `samp_strobe` goes low at the 2nd tick and high again at the 8th tick. This repeats every 16 ticks with no gap, for ten bit periods per complete frame. `samp_strobe` changes only in the cycle after a tick.
- R4: Each bit is captured from the line at the tick where `samp_strobe` rises. Line noise in the first and last quarter of a bit period does not change the received byte.
- R5: If the line is 1 when the start bit is captured, the frame is abandoned. No byte is produced, the strobe returns to 1, and the receiver waits for a new start edge.
- R6: The first data bit after the start bit lands in `rx_data[0]` and the eighth lands in `rx_data[7]`.
- R7: `rx_frm_err` is 1 with the delivered byte when the stop bit is captured as 0. It is 0 when the stop bit is captured as 1.
- R8: After the stop bit is captured, `samp_strobe` stays 1 until the next start edge.
- R9: `rx_valid` stays high, and `rx_data` and `rx_frm_err` stay unchanged, until a cycle with `rx_valid` and `rx_ready` both high. The only exception is when a new byte completes.
- R10: When a byte completes while a previous byte is still waiting and not being accepted in that cycle, the new byte replaces the old one and `rx_overrun` is 1. `rx_overrun` clears when that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_16x | input | 1 | One-cycle enable at 16x baud |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| samp_strobe | output | 1 | Bit-sampling strobe, rising edge marks capture |
| rx_data | output | 8 | Received byte, bit 0 received first |
| rx_valid | output | 1 | Byte presented |
| rx_ready | input | 1 | Consumer accepts byte when high with rx_valid |
| rx_frm_err | output | 1 | Stop bit was 0 for the presented byte |
| rx_overrun | output | 1 | Presented byte replaced an unaccepted one |

## Verification
The hardest case to reach is the overrun. It needs two complete frames to finish while the consumer keeps `rx_ready` low across about 1300 clock cycles, and then the accepting beat must carry the second byte with the flag set. The bench holds ready low on purpose across two frames to get there. It also builds a glitch start that returns high well before mid-bit, and a framing-error frame whose line then stays low. The second case proves that a low level without an edge starts nothing. Random bytes with random edge noise and occasional bad stop bits cover the rest, and the strobe's low-cycle and rising-edge counts are checked for every frame.

// File: rtl/rxos_pkg.sv
`timescale 1ns/1ps
package rxos_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  localparam int unsigned RXOS_DATA_BITS   = 8;
  localparam int unsigned RXOS_OVERSAMPLE  = 16;
  localparam int unsigned RXOS_STROBE_FALL = 2;
  localparam int unsigned RXOS_STROBE_RISE = 8;
endpackage

// File: rtl/rxos_sync.sv
`timescale 1ns/1ps
module rxos_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= {sr_q[STAGES-2:0], din};
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/rxos_bit_timer.sv
`timescale 1ns/1ps
module rxos_bit_timer #(
  parameter int OVS  = 16,
  parameter int FALL = 2,
  parameter int RISE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic run,
  output logic sample_en,
  output logic strobe
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);
  localparam logic [CW-1:0] FALL_C = CW'(FALL);
  localparam logic [CW-1:0] RISE_C = CW'(RISE);
  localparam logic [CW-1:0] SAMP_C = CW'(RISE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= '0;
    else if (run && tick)   cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
  end

  assign sample_en = run && tick && (cnt_q == SAMP_C);
  assign strobe    = !(run && (cnt_q >= FALL_C) && (cnt_q < RISE_C));

  // strobe edges are paced by the tick enable only
  assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe) |-> $past(tick));

  // capture coincides with the strobe's rising edge
  assert_capture_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> $rose(strobe));
endmodule

// File: rtl/rxos_framer.sv
`timescale 1ns/1ps
module rxos_framer
  import rxos_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 sample_en,
  output logic                 run,
  output logic                 start,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 frm_err
);
  localparam int IW = $clog2(DATA_BITS + 2);
  localparam logic [IW-1:0] STOP_IDX = IW'(DATA_BITS + 1);

  rx_state_e            state_q;
  logic                 prev_q;
  logic [IW-1:0]        idx_q;
  logic [DATA_BITS-1:0] sh_q;

  assign run   = (state_q == RX_RUN);
  assign start = (state_q == RX_IDLE) && tick && prev_q && !line;
  assign done  = sample_en && (idx_q == STOP_IDX);
  assign data  = sh_q;
  assign frm_err = !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b1;
    else if (tick)   prev_q <= line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
    end else if (start) begin
      state_q <= RX_RUN;
      idx_q   <= '0;
    end else if (sample_en) begin
      if (idx_q == '0) begin
        if (line) state_q <= RX_IDLE;
        else      idx_q   <= idx_q + 1'b1;
      end else if (idx_q == STOP_IDX) begin
        state_q <= RX_IDLE;
      end else begin
        sh_q  <= {line, sh_q[DATA_BITS-1:1]};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_false_start_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && (idx_q == '0) && line) |=> !run);

  assert_start_enters_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run && (idx_q == '0));
endmodule

// File: rtl/rxos_out_stage.sv
`timescale 1ns/1ps
module rxos_out_stage #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 frm_err,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_frm_err,
  output logic                 out_overrun
);
  logic accept;
  assign accept = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_frm_err <= 1'b0;
      out_overrun <= 1'b0;
    end else if (done) begin
      out_valid   <= 1'b1;
      out_data    <= data;
      out_frm_err <= frm_err;
      out_overrun <= out_valid && !out_ready;
    end else if (accept) begin
      out_valid   <= 1'b0;
      out_frm_err <= 1'b0;
      out_overrun <= 1'b0;
    end
  end

  assert_hold_until_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !done) |=> out_valid && $stable(out_data) && $stable(out_frm_err));

  assert_overrun_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_overrun |-> out_valid);

  assert_overrun_on_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_valid && !out_ready) |=> out_overrun);
endmodule

// File: rtl/serial_rx_os16.sv
`timescale 1ns/1ps
module serial_rx_os16
  import rxos_pkg::*;
#(
  parameter int DATA_BITS   = RXOS_DATA_BITS,
  parameter int OVS         = RXOS_OVERSAMPLE,
  parameter int STROBE_FALL = RXOS_STROBE_FALL,
  parameter int STROBE_RISE = RXOS_STROBE_RISE,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_16x,
  input  logic                 rx_line,
  output logic                 samp_strobe,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 rx_frm_err,
  output logic                 rx_overrun
);
  logic line_s, run, start, done, sample_en, frm_err;
  logic [DATA_BITS-1:0] data;

  rxos_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rxos_bit_timer #(.OVS(OVS), .FALL(STROBE_FALL), .RISE(STROBE_RISE)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .start(start), .run(run),
    .sample_en(sample_en), .strobe(samp_strobe)
  );

  rxos_framer #(.DATA_BITS(DATA_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .line(line_s), .sample_en(sample_en),
    .run(run), .start(start), .done(done), .data(data), .frm_err(frm_err)
  );

  rxos_out_stage #(.DATA_BITS(DATA_BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .done(done), .data(data), .frm_err(frm_err),
    .out_ready(rx_ready), .out_valid(rx_valid), .out_data(rx_data),
    .out_frm_err(rx_frm_err), .out_overrun(rx_overrun)
  );

  // strobe parked high once the stop bit is taken
  assert_parked_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> samp_strobe && !run);
endmodule

// File: tb/serial_rx_os16_tb_top.sv
`timescale 1ns/1ps
module serial_rx_os16_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_16x = 1'b0;
  logic rx_line = 1'b1;
  logic rx_ready = 1'b1;
  logic samp_strobe, rx_valid, rx_frm_err, rx_overrun;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int low_cnt = 0;
  int rise_cnt = 0;
  int beats = 0;
  logic prev_strobe = 1'b1;
  logic [7:0] last_data = '0;
  logic last_frm = 1'b0;
  logic last_ovr = 1'b0;

  always #2 clk = ~clk;

  serial_rx_os16 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_line(rx_line),
    .samp_strobe(samp_strobe), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_frm_err(rx_frm_err), .rx_overrun(rx_overrun)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick_16x = (div == TICK_DIV - 1);
      div = (div + 1) % TICK_DIV;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!samp_strobe) low_cnt++;
      if (samp_strobe && !prev_strobe) rise_cnt++;
      if (rx_valid && rx_ready) begin
        beats++;
        last_data = rx_data;
        last_frm  = rx_frm_err;
        last_ovr  = rx_overrun;
      end
    end
    prev_strobe = samp_strobe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_low_cycles(input int bit_periods);
    return bit_periods * 6 * TICK_DIV;
  endfunction

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input bit noise);
    for (int c = 0; c < BIT_CLKS; c++) begin
      rx_line = (noise && (c < 6 || c >= 50)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [7:0] d, input logic stop, input bit noise);
    send_bit(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) send_bit(d[b], noise);
    send_bit(stop, 1'b0);
  endtask

  // full frame with ready high, then idle gap, checking byte and strobe
  task automatic run_frame(input logic [7:0] d, input logic stop, input bit noise);
    int b0, l0, r0;
    b0 = beats; l0 = low_cnt; r0 = rise_cnt;
    send_bits(d, stop, noise);
    rx_line = 1'b1;
    chk(beats == b0 + 1, "R6 one byte per frame", beats - b0, 1);
    chk(last_data == d, noise ? "R4 noisy byte" : "R6 byte lsb first", last_data, d);
    chk(last_frm == !stop, "R7 framing flag", last_frm, !stop);
    chk(low_cnt - l0 == exp_low_cycles(10), "R3 strobe low cycles", low_cnt - l0, exp_low_cycles(10));
    chk(rise_cnt - r0 == 10, "R3 strobe rises", rise_cnt - r0, 10);
    l0 = low_cnt;
    wait_clks(40);
    chk(low_cnt == l0 && samp_strobe, "R8 strobe parked high", low_cnt - l0, 0);
  endtask

  initial begin
    int b0, l0, r0;
    void'($urandom(32'd2718));
    wait_clks(5);
    chk(samp_strobe == 1'b1, "R1 strobe in reset", samp_strobe, 1);
    chk(rx_valid == 1'b0 && rx_frm_err == 1'b0 && rx_overrun == 1'b0, "R1 flags in reset",
        {rx_valid, rx_frm_err, rx_overrun}, 0);
    rst_n = 1'b1;
    wait_clks(20);
    chk(samp_strobe == 1'b1 && rx_valid == 1'b0, "R1 idle after reset", {samp_strobe, rx_valid}, 2);

    // directed frames
    run_frame(8'h01, 1'b1, 1'b0);
    run_frame(8'h80, 1'b1, 1'b0);
    run_frame(8'h5A, 1'b1, 1'b1);

    // false start: short low pulse
    b0 = beats; l0 = low_cnt; r0 = rise_cnt;
    rx_line = 1'b0; wait_clks(3 * TICK_DIV);
    rx_line = 1'b1; wait_clks(BIT_CLKS + 40);
    chk(beats == b0, "R5 no byte from glitch", beats - b0, 0);
    chk(low_cnt - l0 == exp_low_cycles(1), "R5 strobe one low window", low_cnt - l0, exp_low_cycles(1));
    chk(rise_cnt - r0 == 1 && samp_strobe, "R5 strobe back high", rise_cnt - r0, 1);
    run_frame(8'hC3, 1'b1, 1'b0);

    // framing error then line held low: no edge, no new frame
    b0 = beats;
    send_bits(8'h96, 1'b0, 1'b0);
    chk(beats == b0 + 1 && last_frm && last_data == 8'h96, "R7 bad stop flagged", last_data, 8'h96);
    l0 = low_cnt; b0 = beats;
    rx_line = 1'b0; wait_clks(3 * BIT_CLKS);
    chk(low_cnt == l0 && beats == b0, "R2 level low starts nothing", low_cnt - l0, 0);
    rx_line = 1'b1; wait_clks(40);
    run_frame(8'h3E, 1'b1, 1'b0);

    // back-pressure and overrun
    rx_ready = 1'b0;
    b0 = beats;
    send_bits(8'hA5, 1'b1, 1'b0); rx_line = 1'b1;
    wait_clks(100);
    chk(rx_valid && rx_data == 8'hA5 && !rx_overrun, "R9 held while not ready", rx_data, 8'hA5);
    chk(beats == b0, "R9 no transfer without ready", beats - b0, 0);
    send_bits(8'h3C, 1'b0, 1'b0); rx_line = 1'b1;
    wait_clks(10);
    chk(rx_valid && rx_data == 8'h3C, "R10 newer byte replaces", rx_data, 8'h3C);
    chk(rx_overrun == 1'b1 && rx_frm_err == 1'b1, "R10 overrun raised", {rx_overrun, rx_frm_err}, 3);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(beats == b0 + 1 && last_ovr && last_data == 8'h3C, "R10 accepted with overrun", last_ovr, 1);
    chk(!rx_valid && !rx_overrun, "R10 overrun cleared", {rx_valid, rx_overrun}, 0);
    wait_clks(20);

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic stop;
      bit noise;
      d = 8'($urandom);
      stop = (($urandom % 8) != 0);
      noise = (($urandom % 2) == 1);
      run_frame(d, stop, noise);
      wait_clks(int'($urandom % 30));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule